// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block receives configuration words over a three-wire serial port (a data line, a bit clock and a load strobe). It routes each word into one of a small set of configuration holding registers. Bits are taken in on rising edges of the bit clock, most significant bit first, into a 24-bit shift register. A rising edge on the load strobe then copies the upper 22 bits of the word into the holding register that the two lowest bits of the same word select. The holding registers drive the divider ratios, pulse-width selects and lock-detect options of the surrounding frequency synthesizer.

The three serial pins are not used as clocks. All three pass through synchronizer chains into the system clock domain, and the bit clock and the strobe are turned into single-cycle rising-edge pulses there. The system clock must therefore run several times faster than the serial bit rate. Word width, select width and synchronizer depth are parameters. The number of holding registers follows from the select width.

Top module: `cfg_serial_port`

## Requirements
- R1: While reset is asserted and after it is released, all four holding registers read zero until the first load.
- R2: Each rising edge of the serial bit clock shifts the current data bit into the shift register, most significant bit first. The data line level at the falling edge has no effect.
- R3: On a rising edge of the load strobe, bits 23..2 of the shift register are copied into holding register n, where n is bits 1..0 read as an unsigned number (00 selects register 0, 01 register 1, 10 register 2, 11 register 3). Bit 23 lands in output bit 21.
- R4: A load changes only the selected holding register. The other three keep their values.
- R5: Shifting in a complete word without a load strobe rising edge leaves all holding registers unchanged.
- R6: With the default synchronizer depth of 2, a holding register shows its new value after the third system clock edge following the strobe going high, and not after the second.
- R7: When more than 24 bits are shifted in before a load, only the last 24 bits shifted in are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, sampled asynchronously |
| ser_data | input | 1 | Serial data, sampled asynchronously |
| ser_load | input | 1 | Load strobe, sampled asynchronously |
| bank_q | output | 4 x 22 | Holding registers, entry n is register n |

## Verification
A shifted bit enters the shift register two edges plus one cycle after the bit clock rises. The bench keeps each serial level steady for four system clocks, so every bit is well past that window before the next change. The holding registers are due on exactly the third system edge after the strobe rises. The bench raises the strobe at a falling edge of the system clock and samples at the falling edges after the second and third rising edges, which pins the latency to one cycle. All other checks sample once the strobe has been low for several cycles.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   localparam int unsigned DEF_WORD_W = 24;
   localparam int unsigned DEF_SEL_W  = 2;
   localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/cfg_sync_chain.sv
module cfg_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cfg_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_rise_detect.sv
module cfg_rise_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
   parameter int unsigned WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o
);
   generate
      if (WIDTH < 2) begin : g_bad
         $error("cfg_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (shift_i) word_o <= {word_o[WIDTH-2:0], bit_i};
   end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
   parameter int unsigned PAY_W = 22,
   parameter int unsigned SEL_W = 2,
   localparam int unsigned N_REG = 1 << SEL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic [SEL_W-1:0]            sel_i,
   input  logic [PAY_W-1:0]            pay_i,
   output logic [N_REG-1:0][PAY_W-1:0] bank_o
);
   generate
      for (genvar n = 0; n < N_REG; n++) begin : g_reg
         logic hit;
         assign hit = load_i && (sel_i == SEL_W'(n));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bank_o[n] <= '0;
            else if (hit) bank_o[n] <= pay_i;
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter int unsigned SEL_W  = DEF_SEL_W,
   parameter int unsigned SYNC_N = DEF_SYNC_N,
   localparam int unsigned PAY_W = WORD_W - SEL_W,
   localparam int unsigned N_REG = 1 << SEL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ser_clk,
   input  logic                        ser_data,
   input  logic                        ser_load,
   output logic [N_REG-1:0][PAY_W-1:0] bank_q
);
   logic clk_s, data_s, load_s;
   logic bit_rise, load_rise;
   logic [WORD_W-1:0] shift_q;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("cfg_serial_port: SEL_W out of range 1..4");
      end
      if (WORD_W <= SEL_W) begin : g_bad_word
         $error("cfg_serial_port: WORD_W must exceed SEL_W");
      end
   endgenerate

   cfg_sync_chain #(.STAGES(SYNC_N)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_i(ser_clk), .sync_o(clk_s));
   cfg_sync_chain #(.STAGES(SYNC_N)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .async_i(ser_data), .sync_o(data_s));
   cfg_sync_chain #(.STAGES(SYNC_N)) u_sync_load (
      .clk(clk), .rst_n(rst_n), .async_i(ser_load), .sync_o(load_s));

   cfg_rise_detect u_edge_clk (
      .clk(clk), .rst_n(rst_n), .level_i(clk_s), .rise_o(bit_rise));
   cfg_rise_detect u_edge_load (
      .clk(clk), .rst_n(rst_n), .level_i(load_s), .rise_o(load_rise));

   cfg_shift_reg #(.WIDTH(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_i(bit_rise), .bit_i(data_s),
      .word_o(shift_q));

   cfg_latch_bank #(.PAY_W(PAY_W), .SEL_W(SEL_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .load_i(load_rise),
      .sel_i(shift_q[SEL_W-1:0]), .pay_i(shift_q[WORD_W-1:SEL_W]),
      .bank_o(bank_q));
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned SEL_W  = 2,
   localparam int unsigned PAY_W = WORD_W - SEL_W,
   localparam int unsigned N_REG = 1 << SEL_W
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bit_rise,
   input logic                        data_s,
   input logic                        load_rise,
   input logic [WORD_W-1:0]           shift_q,
   input logic [N_REG-1:0][PAY_W-1:0] bank_q
);
   a_r1_clear_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (bank_q == '0));

   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      bit_rise |=> (shift_q == {$past(shift_q[WORD_W-2:0]), $past(data_s)}));

   a_r5_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_rise |=> $stable(bank_q));

   generate
      for (genvar n = 0; n < N_REG; n++) begin : g_chk
         a_r3_load_selected: assert property (@(posedge clk) disable iff (!rst_n)
            (load_rise && shift_q[SEL_W-1:0] == SEL_W'(n))
            |=> (bank_q[n] == $past(shift_q[WORD_W-1:SEL_W])));
         a_r4_others_keep: assert property (@(posedge clk) disable iff (!rst_n)
            !(load_rise && shift_q[SEL_W-1:0] == SEL_W'(n)) |=> $stable(bank_q[n]));
      end
   endgenerate
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .data_s(data_s),
   .load_rise(load_rise), .shift_q(shift_q), .bank_q(bank_q));

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W = 24;
   localparam int PAY_W  = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic [3:0][PAY_W-1:0] bank_q;
   logic [PAY_W-1:0] exp_bank [4];
   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .bank_q(bank_q));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R2: the data line is flipped while the bit clock is high
   task automatic shift_bit(input logic b);
      ser_data = b;  wait_neg(4);
      ser_clk = 1'b1; wait_neg(4);
      ser_data = ~b; wait_neg(1);
      ser_clk = 1'b0; wait_neg(3);
   endtask

   task automatic send_bits(input logic [63:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
   endtask

   task automatic pulse_load();
      ser_load = 1'b1; wait_neg(5);
      ser_load = 1'b0; wait_neg(5);
   endtask

   task automatic check_all(input string tag);
      for (int r = 0; r < 4; r++) check(tag, 32'(bank_q[r]), 32'(exp_bank[r]));
   endtask

   initial begin
      wait_neg(3);
      for (int r = 0; r < 4; r++) exp_bank[r] = '0;
      check_all("R1 during reset");
      rst_n = 1'b1;
      wait_neg(3);
      check_all("R1 after reset");

      // R3/R4/R2 sweep: every select with several payloads
      for (int k = 0; k < 6; k++) begin
         for (int s = 0; s < 4; s++) begin
            logic [PAY_W-1:0] pay;
            if (k == 0)      pay = '0;
            else if (k == 5) pay = '1;
            else             pay = PAY_W'((k * 32'h1357B) ^ (s << 19) ^ 32'h0F0F0);
            send_bits({40'd0, pay, 2'(s)}, WORD_W);
            pulse_load();
            exp_bank[s] = pay;
            check_all("R3/R4 load sweep");
         end
      end

      // R5: full word, no strobe
      send_bits({40'd0, 22'h155555, 2'd1}, WORD_W);
      wait_neg(5);
      check_all("R5 no strobe no change");

      // R6: exact latency of the load
      send_bits({40'd0, 22'h2C3A17, 2'd2}, WORD_W);
      ser_load = 1'b1;
      wait_neg(2);
      check("R6 not yet after 2 edges", 32'(bank_q[2]), 32'(exp_bank[2]));
      wait_neg(1);
      exp_bank[2] = 22'h2C3A17;
      check("R6 due after 3 edges", 32'(bank_q[2]), 32'(exp_bank[2]));
      wait_neg(3);
      ser_load = 1'b0;
      wait_neg(5);
      check_all("R6 others");

      // R7: extra leading bits are dropped
      send_bits({34'd0, 6'b101101, 22'h0ABCDE, 2'd3}, 30);
      pulse_load();
      exp_bank[3] = 22'h0ABCDE;
      check_all("R7 overlong word");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule